// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the device side of a 1K x 8 serial EEPROM that is reached over a four-wire SPI bus in mode 0. An on-chip register array stands in for the non-volatile cells. A host selects the device by pulling the select line low and shifts instructions in, most significant bit first. The block decodes six instructions: set the write-enable latch, clear it, read the status byte, write the status byte, read data, and write data. Read data and status leave on the serial output. The output changes on the falling clock edge so that the host can sample it on the rising edge.

The protection rules of such a part are enforced. Every instruction that changes state needs the write-enable latch to be set first, and it takes effect only when select is released on an exact byte boundary after its last qualifying bit. A two-bit protect code in the status byte makes a region of the array read-only. The write-protect pin freezes that code. Data writes are first collected in a 32-byte page buffer. Once the instruction qualifies, the buffer is copied into the array one byte per system cycle. A busy flag is held for a fixed number of system cycles while this runs.

All serial inputs are brought into the system clock domain through two-flop synchronisers, and edges are found from the synchronised copies.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Opcodes are 0x06 set-enable, 0x04 clear-enable, 0x05 read-status, 0x01 write-status, 0x03 read, 0x02 write. The status byte is {4'b0000, PROT[1:0], WEL, BUSY}, with BUSY in bit 0 and WEL in bit 1. Read-status returns it MSB first, reloaded at every byte boundary for as long as select stays low.
- R2: Set-enable makes WEL 1 only if select rises after exactly 8 serial clocks.
- R3: Clear-enable makes WEL 0 only if select rises after exactly 8 serial clocks.
- R4: Write-status takes the opcode plus one data byte. It acts only if WEL is set and select rises after exactly 16 clocks. It then loads PROT from data bits [3:2] and clears WEL. Any other case changes nothing.
- R5: While wp_n is low, a qualifying write-status clears WEL but leaves PROT unchanged.
- R6: Read takes the opcode and a 16-bit address, MSB first, of which only the low 10 bits are used. It then streams bytes from that address. The address increments after each byte and wraps from 0x3FF to 0x000.
- R7: Write takes the opcode, a 16-bit address and one or more data bytes. It commits only if WEL is set and select rises after a whole number of bytes. A commit clears WEL. Otherwise the array is unchanged.
- R8: The data bytes of one write fill consecutive addresses and wrap inside the 32-byte page of the start address.
- R9: PROT 00 protects nothing, 01 protects 0x300–0x3FF, 10 protects 0x200–0x3FF, and 11 protects the whole array. A write whose start address is protected changes nothing and leaves WEL set.
- R10: After a commit, BUSY reads 1 for BUSY_CYCLES system cycles. Any instruction whose opcode completes while BUSY is 1 is ignored, except read-status.
- R11: miso is 0 while select is high, and it is 0 during input-only phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears WEL, PROT and BUSY and erases the array to 0xFF |
| cs_n | input | 1 | Active-low device select from the SPI host |
| sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| mosi | input | 1 | Serial data in, sampled on rising sclk |
| wp_n | input | 1 | Active-low write protect; when low, PROT cannot change |
| miso | output | 1 | Serial data out, changed after falling sclk; 0 when not driving |

## Verification
Each serial input passes two synchroniser flops, and the state register adds one more cycle. A serial edge therefore acts about three system cycles after the bench drives it, and a new miso bit appears three cycles after a falling sclk. The bench holds each sclk level for six system cycles and samples miso just before it raises sclk. The result of an instruction is due about three cycles after select rises. The bench waits 24 cycles after each release before starting the next transaction. BUSY runs for BUSY_CYCLES cycles from that point. Checks that must see BUSY high are issued within the first few hundred cycles, and checks that must see it low come only after a wait of BUSY_CYCLES plus a margin.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_SET_EN  = 8'h06;
    localparam logic [7:0] OP_CLR_EN  = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_DATA = 8'h03;
    localparam logic [7:0] OP_WR_DATA = 8'h02;

    typedef enum logic [2:0] {
        CMD_OPC,
        CMD_SETEN,
        CMD_CLREN,
        CMD_RDST,
        CMD_WRST,
        CMD_RDDAT,
        CMD_WRDAT,
        CMD_IGN
    } cmd_e;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int              LINES   = 3,
    parameter int              STAGES  = 2,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
            else        chain_q <= {chain_q[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_ee_guard.sv
module spi_ee_guard #(
    parameter int AW = 10
) (
    input  logic [1:0]    prot,
    input  logic [AW-1:0] addr,
    output logic          locked
);

    always_comb begin
        unique case (prot)
            2'b00:   locked = 1'b0;
            2'b01:   locked = (addr[AW-1:AW-2] == 2'b11);
            2'b10:   locked = addr[AW-1];
            default: locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int         AW   = 10,
    parameter int         DW   = 8,
    parameter logic [7:0] INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= DW'(INIT);
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
    parameter int AW          = 10,
    parameter int PAGE_W      = 5,
    parameter int BUSY_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);
    import spi_ee_pkg::*;

    localparam int PAGE = 1 << PAGE_W;
    localparam int BCW  = $clog2(BUSY_CYCLES + 1);
    localparam int CIW  = PAGE_W + 1;
    localparam int PBW  = AW - PAGE_W;

    typedef struct packed {
        cmd_e                  cmd;
        logic                  cs_p;
        logic                  sclk_p;
        logic [2:0]            bitn;
        logic [2:0]            bytes;
        logic [7:0]            sh;
        logic [15:0]           a16;
        logic [AW-1:0]         ptr;
        logic                  locked;
        logic [7:0]            nxt;
        logic                  pend;
        logic [7:0]            sr;
        logic [7:0]            wsr;
        logic                  wel;
        logic [1:0]            prot;
        logic [BCW-1:0]        bcnt;
        logic [CIW-1:0]        cidx;
        logic [PBW-1:0]        pbase;
        logic [PAGE_W-1:0]     poff;
        logic [PAGE-1:0]       pmask;
        logic [PAGE-1:0][7:0]  pbuf;
    } st_t;

    st_t s_q, s_d;

    logic [2:0]    sync_out;
    logic          cs_s, sclk_s, mosi_s;
    logic          cs_rise, sclk_rise, sclk_fall;
    logic          busy;
    logic [7:0]    status, byte_in;
    logic [15:0]   a16_new;
    logic [AW-1:0] rd_addr, mem_waddr;
    logic [7:0]    rd_data, mem_wdata;
    logic          mem_we, lock_new;

    spi_ee_sync #(.LINES(3), .STAGES(2), .RST_VAL(3'b100)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, mosi}),
        .dout (sync_out)
    );

    assign cs_s   = sync_out[2];
    assign sclk_s = sync_out[1];
    assign mosi_s = sync_out[0];

    assign cs_rise   = cs_s & ~s_q.cs_p;
    assign sclk_rise = sclk_s & ~s_q.sclk_p;
    assign sclk_fall = ~sclk_s & s_q.sclk_p;

    assign busy    = (s_q.bcnt != '0);
    assign status  = {4'b0000, s_q.prot, s_q.wel, busy};
    assign byte_in = {s_q.sh[6:0], mosi_s};
    assign a16_new = {s_q.a16[7:0], byte_in};
    assign rd_addr = (s_q.bytes == 3'd2) ? a16_new[AW-1:0] : s_q.ptr;

    spi_ee_guard #(.AW(AW)) guard_i (
        .prot  (s_q.prot),
        .addr  (a16_new[AW-1:0]),
        .locked(lock_new)
    );

    spi_ee_array #(.AW(AW), .DW(8), .INIT(8'hFF)) array_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;

        s_d.cs_p   = cs_s;
        s_d.sclk_p = sclk_s;

        // paced commit of the page buffer while busy
        if (busy) begin
            s_d.bcnt = s_q.bcnt - 1'b1;
            if (s_q.cidx < CIW'(PAGE)) begin
                if (s_q.pmask[s_q.cidx[PAGE_W-1:0]]) begin
                    mem_we    = 1'b1;
                    mem_waddr = {s_q.pbase, s_q.cidx[PAGE_W-1:0]};
                    mem_wdata = s_q.pbuf[s_q.cidx[PAGE_W-1:0]];
                end
                s_d.cidx = s_q.cidx + 1'b1;
            end
        end

        if (cs_s) begin
            s_d.cmd   = CMD_OPC;
            s_d.bitn  = '0;
            s_d.bytes = '0;
            s_d.sr    = '0;
            s_d.pend  = 1'b0;
            if (cs_rise && s_q.bitn == 3'd0) begin
                unique case (s_q.cmd)
                    CMD_SETEN: if (s_q.bytes == 3'd1) s_d.wel = 1'b1;
                    CMD_CLREN: if (s_q.bytes == 3'd1) s_d.wel = 1'b0;
                    CMD_WRST: begin
                        if (s_q.bytes == 3'd2 && s_q.wel) begin
                            if (wp_n) s_d.prot = s_q.wsr[3:2];
                            s_d.wel = 1'b0;
                        end
                    end
                    CMD_WRDAT: begin
                        if (s_q.bytes >= 3'd4 && s_q.wel && !s_q.locked) begin
                            s_d.bcnt = BCW'(BUSY_CYCLES);
                            s_d.cidx = '0;
                            s_d.wel  = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end else begin
            if (sclk_rise) begin
                s_d.sh   = byte_in;
                s_d.bitn = s_q.bitn + 1'b1;
                if (s_q.bitn == 3'd7) begin
                    if (s_q.bytes != 3'd7) s_d.bytes = s_q.bytes + 1'b1;
                    if (s_q.bytes == 3'd0) begin
                        if (busy && byte_in != OP_RD_STAT) begin
                            s_d.cmd = CMD_IGN;
                        end else begin
                            unique case (byte_in)
                                OP_SET_EN:  s_d.cmd = CMD_SETEN;
                                OP_CLR_EN:  s_d.cmd = CMD_CLREN;
                                OP_WR_STAT: s_d.cmd = CMD_WRST;
                                OP_RD_DATA: s_d.cmd = CMD_RDDAT;
                                OP_WR_DATA: s_d.cmd = CMD_WRDAT;
                                OP_RD_STAT: begin
                                    s_d.cmd  = CMD_RDST;
                                    s_d.nxt  = status;
                                    s_d.pend = 1'b1;
                                end
                                default:    s_d.cmd = CMD_IGN;
                            endcase
                        end
                    end else begin
                        unique case (s_q.cmd)
                            CMD_RDST: begin
                                s_d.nxt  = status;
                                s_d.pend = 1'b1;
                            end
                            CMD_WRST: if (s_q.bytes == 3'd1) s_d.wsr = byte_in;
                            CMD_RDDAT, CMD_WRDAT: begin
                                if (s_q.bytes <= 3'd2) begin
                                    s_d.a16 = a16_new;
                                    if (s_q.bytes == 3'd2) begin
                                        if (s_q.cmd == CMD_RDDAT) begin
                                            s_d.nxt  = rd_data;
                                            s_d.pend = 1'b1;
                                            s_d.ptr  = a16_new[AW-1:0] + 1'b1;
                                        end else begin
                                            s_d.locked = lock_new;
                                            s_d.pbase  = a16_new[AW-1:PAGE_W];
                                            s_d.poff   = a16_new[PAGE_W-1:0];
                                            s_d.pmask  = '0;
                                        end
                                    end
                                end else if (s_q.cmd == CMD_RDDAT) begin
                                    s_d.nxt  = rd_data;
                                    s_d.pend = 1'b1;
                                    s_d.ptr  = s_q.ptr + 1'b1;
                                end else begin
                                    s_d.pbuf[s_q.poff]  = byte_in;
                                    s_d.pmask[s_q.poff] = 1'b1;
                                    s_d.poff            = s_q.poff + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
            if (sclk_fall) begin
                if (s_q.pend) begin
                    s_d.sr   = s_q.nxt;
                    s_d.pend = 1'b0;
                end else begin
                    s_d.sr = {s_q.sr[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cmd  <= CMD_OPC;
            s_q.cs_p <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso = s_q.sr[7];

    // R7
    commit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(s_q.wel));

    // R7
    commit_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !s_q.wel);

    // R5
    prot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(s_q.prot));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !miso);

    // R10
    store_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

// File: tb/spi_eeprom_ctrl_tb_top.sv
module spi_eeprom_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int BUSY       = 600;
    localparam int MAX_CYC    = 200000;

    typedef logic [7:0] u8;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, mosi, wp_n;
    logic miso;

    int checks = 0;
    int fails  = 0;
    int idle_cnt = 0;
    bit done = 1'b0;

    u8  mem_m [1024];
    bit wel_m;
    bit [1:0] prot_m;
    bit busy_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_ctrl #(.AW(10), .PAGE_W(5), .BUSY_CYCLES(BUSY)) dut_i (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (cs_n),
        .sclk (sclk),
        .mosi (mosi),
        .wp_n (wp_n),
        .miso (miso)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // R11: output quiet while deselected, compared every clock
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (cs_n) idle_cnt++; else idle_cnt = 0;
            if (idle_cnt > 4) chk("R11 idle miso", int'(miso), 0);
        end
    end

    function automatic bit locked_m(input int a);
        case (prot_m)
            2'b00:   return 1'b0;
            2'b01:   return a >= 'h300;
            2'b10:   return a >= 'h200;
            default: return 1'b1;
        endcase
    endfunction

    function automatic u8 status_m();
        return {4'b0000, prot_m, wel_m, busy_m};
    endfunction

    task automatic xfer(input u8 tx[$], input int extra, output u8 rx[$]);
        u8 cur;
        rx = {};
        @(negedge clk);
        cs_n = 1'b0;
        foreach (tx[k]) begin
            cur = '0;
            for (int b = 7; b >= 0; b--) begin
                mosi = tx[k][b];
                repeat (HALF) @(negedge clk);
                cur[b] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
            rx.push_back(cur);
        end
        for (int e = 0; e < extra; e++) begin
            mosi = 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic set_en(input int extra);
        u8 rx[$];
        xfer('{8'h06}, extra, rx);
        if (!busy_m && extra == 0) wel_m = 1'b1;
    endtask

    task automatic clr_en(input int extra);
        u8 rx[$];
        xfer('{8'h04}, extra, rx);
        if (!busy_m && extra == 0) wel_m = 1'b0;
    endtask

    task automatic rd_stat(input string tag);
        u8 rx[$];
        xfer('{8'h05, 8'h00, 8'h00}, 0, rx);
        chk(tag, rx[1], status_m());
        chk(tag, rx[2], status_m());
    endtask

    task automatic wr_stat(input u8 val, input int extra);
        u8 rx[$];
        xfer('{8'h01, val}, extra, rx);
        if (!busy_m && extra == 0 && wel_m) begin
            if (wp_n) prot_m = val[3:2];
            wel_m = 1'b0;
        end
    endtask

    task automatic wr_data(input int a16, input u8 d[$], input int extra);
        u8 tx[$];
        u8 rx[$];
        int a;
        tx = '{8'h02, u8'(a16 >> 8), u8'(a16)};
        foreach (d[k]) tx.push_back(d[k]);
        xfer(tx, extra, rx);
        a = a16 % 1024;
        if (!busy_m && extra == 0 && d.size() > 0 && wel_m && !locked_m(a)) begin
            foreach (d[k]) mem_m[(a & ~31) | ((a + k) & 31)] = d[k];
            wel_m  = 1'b0;
            busy_m = 1'b1;
        end
    endtask

    task automatic settle();
        repeat (BUSY + 60) @(negedge clk);
        busy_m = 1'b0;
    endtask

    task automatic rd_data(input int a16, input int n, input string tag);
        u8 tx[$];
        u8 rx[$];
        tx = '{8'h03, u8'(a16 >> 8), u8'(a16)};
        for (int k = 0; k < n; k++) tx.push_back(8'h00);
        xfer(tx, 0, rx);
        for (int k = 0; k < n; k++)
            chk(tag, rx[3+k], busy_m ? 0 : mem_m[(a16 + k) % 1024]);
        for (int k = 0; k < 3; k++) chk("R11 header miso", rx[k], 0);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        foreach (mem_m[i]) mem_m[i] = 8'hFF;
        wel_m = 0; prot_m = 0; busy_m = 0;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; wp_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 reset miso", int'(miso), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        rd_stat("R1 reset status");
        // R7: write without enable latch
        wr_data('h010, '{8'hAA}, 0);
        rd_data('h010, 1, "R7 no WEL write");
        // R2: nine clocks do not set the latch
        set_en(1);
        rd_stat("R2 set-enable 9 clocks");
        set_en(0);
        rd_stat("R2 set-enable");
        // R3
        clr_en(3);
        rd_stat("R3 clear-enable 11 clocks");
        clr_en(0);
        rd_stat("R3 clear-enable");
        set_en(0);
        // R7: partial byte discards the write
        wr_data('h010, '{8'h11, 8'h22, 8'h33}, 3);
        rd_stat("R7 partial byte keeps WEL");
        rd_data('h010, 1, "R7 partial byte");
        // R7 / R10: real commit, busy visible, instructions ignored
        wr_data('h010, '{8'h11, 8'h22, 8'h33}, 0);
        rd_stat("R10 busy status");
        set_en(0);
        settle();
        rd_stat("R10 set-enable ignored while busy");
        rd_data('h00E, 6, "R6 sequential read");
        // R8: page wrap
        set_en(0);
        wr_data('h03E, '{8'h01, 8'h02, 8'h03, 8'h04}, 0);
        settle();
        rd_data('hFC3E, 2, "R6 upper address bits ignored");
        rd_data('h020, 3, "R8 page wrap");
        rd_data('h03FF, 2, "R6 array wrap");
        // R4: status write
        wr_stat(8'h0C, 0);
        rd_stat("R4 without WEL");
        set_en(0);
        wr_stat(8'h0C, 1);
        rd_stat("R4 17 clocks");
        wr_stat(8'h0C, 0);
        rd_stat("R4 prot 11");
        // R9: whole array locked
        set_en(0);
        wr_data('h000, '{8'h55}, 0);
        rd_stat("R9 locked keeps WEL");
        rd_data('h000, 1, "R9 locked all");
        // R5: write-protect pin
        wp_n = 1'b0;
        wr_stat(8'h04, 0);
        rd_stat("R5 prot frozen");
        wp_n = 1'b1;
        set_en(0);
        wr_stat(8'h04, 0);
        rd_stat("R4 prot 01");
        // R9: upper quarter
        set_en(0);
        wr_data('h300, '{8'h66}, 0);
        rd_stat("R9 quarter locked keeps WEL");
        wr_data('h2FF, '{8'h5A}, 0);
        settle();
        rd_data('h2FF, 2, "R9 quarter boundary");
        set_en(0);
        wr_stat(8'h08, 0);
        set_en(0);
        wr_data('h200, '{8'h77}, 0);
        wr_data('h1FF, '{8'h78}, 0);
        settle();
        rd_data('h1FF, 2, "R9 half boundary");
        rd_stat("R1 final status");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule